// File: doc/BRIEF.md
# Paged CSR window decoder

This block sits between a host register bus with a 4 KB aperture and a larger internal register space of 64 KB. It contains one bridge control register that carries a 6-bit page number and two enable bits for the programmed-I/O paths. Host offsets whose two top bits are both set fall into the paged window. Each such access is redirected to the internal address formed by the page number above the low 10 bits of the offset, so every page spans 1 KB. Every other offset, apart from the control register itself, goes to the internal bus unchanged as a direct access.

The host side accepts one access per cycle and needs no handshake. The access is registered once and then presented on the internal bus in the next cycle. Read data returns to the host one cycle after that. An internal target that does not claim a read leaves the returned data at zero, and no error is raised. Because software places the page number in the control register, a page change applies to the very next host access, including one issued in the following cycle.

Top module: `pcsr_window_dec`

## Requirements
- R1: After reset the internal bus is idle (b_vld low), no read data is flagged (h_rvld low), both enable outputs are low, and the control register reads as zero.
- R2: A host access at an offset whose bits 11:10 are both 1 appears on the internal bus in the following cycle. It carries b_addr = {page, offset[9:0]}, where page is control register bits 18:13 at the time of the access, and it keeps the same write flag and write data.
- R3: A host access at any other offset except 0x808 appears on the internal bus in the following cycle, with b_addr equal to the offset zero-extended to 16 bits.
- R4: An access at offset 0x808 goes to the control register and produces no internal bus cycle.
- R5: A write to offset 0x808 stores all 32 bits, and a later read returns them exactly. Software can therefore change the page field in bits 18:13 by read-modify-write and leave the other bits intact.
- R6: After a control register write, pio_host_en equals bit 0 and pio_link_en equals bit 1 of the written value.
- R7: A page written to the control register in cycle t is used by a paged access issued in cycle t+1.
- R8: A read issued in cycle t sets h_rvld in cycle t+2. h_rdata then holds the control register value for offset 0x808, b_rdata when b_hit is high, and zero when b_hit is low.
- R9: A write never sets h_rvld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_vld | input | 1 | Host access valid this cycle |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 12 | Host byte offset within the aperture |
| h_wdata | input | 32 | Host write data |
| h_rvld | output | 1 | Read data valid |
| h_rdata | output | 32 | Read data |
| b_vld | output | 1 | Internal bus access valid |
| b_we | output | 1 | Internal bus access is a write |
| b_addr | output | 16 | Internal register address |
| b_wdata | output | 32 | Internal write data |
| b_rdata | input | 32 | Internal read data, sampled while b_vld is high |
| b_hit | input | 1 | Internal target exists at b_addr |
| pio_host_en | output | 1 | Control register bit 0 |
| pio_link_en | output | 1 | Control register bit 1 |

## Verification
The bench issues a paged access in the cycle right after a page write. A decoder that sampled the page one cycle late would send that access to the old page. It reads the same internal register once through a direct offset and once through page 1 of the window. An off-by-one in the page shift would make the two addresses disagree. It also writes a control word with high bits set next to the page field, so a design that masked the register on store would lose those bits on readback. Reads of pages marked unimplemented must return zero, and accesses to the control offset must never reach the internal bus. A design that leaked stale data on a miss, or forwarded control accesses, would fail one of these checks.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT = 2'd0,
    ACC_PAGED  = 2'd1,
    ACC_CTRL   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/pcsr_rst_sync.sv
module pcsr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pcsr_addr_dec.sv
module pcsr_addr_dec #(
  parameter int unsigned AP_W  = 12,
  parameter int unsigned PG_W  = 6,
  parameter int unsigned OFS_W = 10,
  parameter int unsigned IA_W  = PG_W + OFS_W,
  parameter logic [AP_W-1:0] CTRL_OFS = 12'h808
) (
  input  logic [AP_W-1:0]       addr,
  input  logic [PG_W-1:0]       page,
  output pcsr_pkg::acc_kind_e   kind,
  output logic [IA_W-1:0]       eff_addr
);
  import pcsr_pkg::*;

  // window select: all offset bits above the in-page field set
  logic in_window;
  assign in_window = &addr[AP_W-1:OFS_W];

  always_comb begin
    if (in_window) begin
      kind     = ACC_PAGED;
      eff_addr = {page, addr[OFS_W-1:0]};
    end else if (addr == CTRL_OFS) begin
      kind     = ACC_CTRL;
      eff_addr = '0;
    end else begin
      kind     = ACC_DIRECT;
      eff_addr = IA_W'(addr);
    end
  end
endmodule

// File: rtl/pcsr_ctrl_reg.sv
module pcsr_ctrl_reg #(
  parameter int unsigned DW     = 32,
  parameter int unsigned PG_W   = 6,
  parameter int unsigned PG_LSB = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   ctrl_q,
  output logic [PG_W-1:0] page,
  output logic            host_en,
  output logic            link_en
);
  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign page    = ctrl_q[PG_LSB +: PG_W];
  assign host_en = ctrl_q[0];
  assign link_en = ctrl_q[1];

  // R6: enables follow the written bits
  p_pio_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (host_en == $past(wdata[0])) && (link_en == $past(wdata[1])));

  // R5: contents only change through a write
  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/pcsr_rd_ret.sv
module pcsr_rd_ret #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_vld,
  input  logic          s_we,
  input  logic          s_local,
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] b_rdata,
  input  logic          b_hit,
  output logic          h_rvld,
  output logic [DW-1:0] h_rdata
);
  logic          rvld_d;
  logic          rdata_en;
  logic [DW-1:0] rdata_d;

  always_comb begin
    rvld_d   = s_vld & ~s_we;
    rdata_en = rvld_d;
    if (s_local)    rdata_d = ctrl_q;
    else if (b_hit) rdata_d = b_rdata;
    else            rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_rvld <= 1'b0;
    else        h_rvld <= rvld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        h_rdata <= '0;
    else if (rdata_en) h_rdata <= rdata_d;
  end

  p_rd_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && !s_we) |=> h_rvld);

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && !s_we && !s_local && !b_hit) |=> (h_rdata == '0));

  p_wr_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && s_we) |=> !h_rvld);
endmodule

// File: rtl/pcsr_window_dec.sv
module pcsr_window_dec #(
  parameter int unsigned AP_W   = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned PG_W   = 6,
  parameter int unsigned PG_LSB = 13,
  parameter int unsigned OFS_W  = 10,
  parameter logic [AP_W-1:0] CTRL_OFS = 12'h808
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  h_vld,
  input  logic                  h_we,
  input  logic [AP_W-1:0]       h_addr,
  input  logic [DW-1:0]         h_wdata,
  output logic                  h_rvld,
  output logic [DW-1:0]         h_rdata,
  output logic                  b_vld,
  output logic                  b_we,
  output logic [PG_W+OFS_W-1:0] b_addr,
  output logic [DW-1:0]         b_wdata,
  input  logic [DW-1:0]         b_rdata,
  input  logic                  b_hit,
  output logic                  pio_host_en,
  output logic                  pio_link_en
);
  import pcsr_pkg::*;

  localparam int unsigned IA_W = PG_W + OFS_W;

  logic            rst_sn;
  logic [DW-1:0]   ctrl_q;
  logic [PG_W-1:0] page;
  acc_kind_e       kind;
  logic [IA_W-1:0] eff_addr;
  logic            ctrl_wr;

  // request stage
  logic            s_vld_q, s_vld_d;
  logic            s_we_q, s_we_d;
  logic            s_local_q, s_local_d;
  logic            s_cap_en;
  logic [IA_W-1:0] s_addr_q, s_addr_d;
  logic [DW-1:0]   s_wdata_q, s_wdata_d;

  pcsr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  pcsr_addr_dec #(
    .AP_W     (AP_W),
    .PG_W     (PG_W),
    .OFS_W    (OFS_W),
    .IA_W     (IA_W),
    .CTRL_OFS (CTRL_OFS)
  ) u_dec (
    .addr     (h_addr),
    .page     (page),
    .kind     (kind),
    .eff_addr (eff_addr)
  );

  assign ctrl_wr = h_vld & h_we & (kind == ACC_CTRL);

  pcsr_ctrl_reg #(
    .DW     (DW),
    .PG_W   (PG_W),
    .PG_LSB (PG_LSB)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (ctrl_wr),
    .wdata   (h_wdata),
    .ctrl_q  (ctrl_q),
    .page    (page),
    .host_en (pio_host_en),
    .link_en (pio_link_en)
  );

  always_comb begin
    s_vld_d   = h_vld;
    s_cap_en  = h_vld;
    s_we_d    = h_we;
    s_local_d = (kind == ACC_CTRL);
    s_addr_d  = eff_addr;
    s_wdata_d = h_wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s_vld_q   <= 1'b0;
      s_we_q    <= 1'b0;
      s_local_q <= 1'b0;
      s_addr_q  <= '0;
      s_wdata_q <= '0;
    end else begin
      s_vld_q <= s_vld_d;
      if (s_cap_en) begin
        s_we_q    <= s_we_d;
        s_local_q <= s_local_d;
        s_addr_q  <= s_addr_d;
        s_wdata_q <= s_wdata_d;
      end
    end
  end

  assign b_vld   = s_vld_q & ~s_local_q;
  assign b_we    = s_vld_q & s_we_q & ~s_local_q;
  assign b_addr  = s_addr_q;
  assign b_wdata = s_wdata_q;

  pcsr_rd_ret #(
    .DW (DW)
  ) u_ret (
    .clk     (clk),
    .rst_n   (rst_sn),
    .s_vld   (s_vld_q),
    .s_we    (s_we_q),
    .s_local (s_local_q),
    .ctrl_q  (ctrl_q),
    .b_rdata (b_rdata),
    .b_hit   (b_hit),
    .h_rvld  (h_rvld),
    .h_rdata (h_rdata)
  );

  // R2 / R7: window access reaches the page held at issue time
  p_paged_addr_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (h_vld && (&h_addr[AP_W-1:OFS_W])) |=>
      b_vld && (b_addr[OFS_W-1:0] == $past(h_addr[OFS_W-1:0])) &&
      (b_addr[IA_W-1:OFS_W] == $past(ctrl_q[PG_LSB +: PG_W])) &&
      (b_we == $past(h_we)));

  p_direct_addr_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (h_vld && !(&h_addr[AP_W-1:OFS_W]) && (h_addr != CTRL_OFS)) |=>
      b_vld && (b_addr == IA_W'($past(h_addr))));

  p_ctrl_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (h_vld && (h_addr == CTRL_OFS)) |=> !b_vld);

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !h_vld |=> !b_vld);
endmodule

// File: tb/tb_pcsr_window_dec.sv
module tb_pcsr_window_dec;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        h_vld;
  logic        h_we;
  logic [11:0] h_addr;
  logic [31:0] h_wdata;
  logic        h_rvld;
  logic [31:0] h_rdata;
  logic        b_vld;
  logic        b_we;
  logic [15:0] b_addr;
  logic [31:0] b_wdata;
  logic [31:0] b_rdata;
  logic        b_hit;
  logic        pio_host_en;
  logic        pio_link_en;

  int checks;
  int errors;
  bit done;
  logic [31:0] m_ctrl;

  pcsr_window_dec dut (
    .clk (clk), .rst_n (rst_n),
    .h_vld (h_vld), .h_we (h_we), .h_addr (h_addr), .h_wdata (h_wdata),
    .h_rvld (h_rvld), .h_rdata (h_rdata),
    .b_vld (b_vld), .b_we (b_we), .b_addr (b_addr), .b_wdata (b_wdata),
    .b_rdata (b_rdata), .b_hit (b_hit),
    .pio_host_en (pio_host_en), .pio_link_en (pio_link_en)
  );

  // internal target model: pages 48..63 unimplemented
  assign b_hit   = (b_addr[15:14] != 2'b11);
  assign b_rdata = {b_addr ^ 16'h5A5A, b_addr};

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [15:0] exp_baddr(logic [11:0] a, logic [31:0] c);
    if (a[11:10] == 2'b11) return {c[18:13], a[9:0]};
    return {4'b0000, a};
  endfunction

  function automatic logic [31:0] exp_rdata(logic [11:0] a, logic [31:0] c);
    logic [15:0] ia;
    if (a == 12'h808) return c;
    ia = exp_baddr(a, c);
    if (ia[15:14] == 2'b11) return 32'h0;
    return {ia ^ 16'h5A5A, ia};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one isolated access, checked on both stages
  task automatic acc(bit we, logic [11:0] a, logic [31:0] wd);
    logic [31:0] c;
    c = m_ctrl;
    @(negedge clk);
    h_vld = 1'b1; h_we = we; h_addr = a; h_wdata = wd;
    @(negedge clk);
    h_vld = 1'b0;
    if (a == 12'h808) begin
      chk(b_vld == 1'b0, "R4 ctrl access kept off bus", 32'(b_vld), 32'd0);
      if (we) begin
        m_ctrl = wd;
        chk({pio_link_en, pio_host_en} == wd[1:0], "R6 enables",
            32'({pio_link_en, pio_host_en}), 32'(wd[1:0]));
      end
    end else begin
      chk(b_vld == 1'b1 && b_we == we, (a[11:10] == 2'b11) ? "R2 paged valid/we" : "R3 direct valid/we",
          32'({b_vld, b_we}), 32'({1'b1, we}));
      chk(b_addr == exp_baddr(a, c), (a[11:10] == 2'b11) ? "R2 paged address" : "R3 direct address",
          32'(b_addr), 32'(exp_baddr(a, c)));
      if (we) chk(b_wdata == wd, "R2 write data", b_wdata, wd);
    end
    @(negedge clk);
    if (we) begin
      chk(h_rvld == 1'b0, "R9 write gives no read data", 32'(h_rvld), 32'd0);
    end else begin
      chk(h_rvld == 1'b1, "R8 read valid", 32'(h_rvld), 32'd1);
      chk(h_rdata == exp_rdata(a, c), (a == 12'h808) ? "R5 ctrl readback" : "R8 read data",
          h_rdata, exp_rdata(a, c));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; m_ctrl = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; h_vld = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(b_vld == 1'b0 && h_rvld == 1'b0, "R1 idle after reset", 32'({b_vld, h_rvld}), 32'd0);
    chk(pio_host_en == 1'b0 && pio_link_en == 1'b0, "R1 enables low",
        32'({pio_link_en, pio_host_en}), 32'd0);
    acc(1'b0, 12'h808, '0);

    // page 1, both enables
    acc(1'b1, 12'h808, 32'h0000_2003);
    acc(1'b0, 12'h808, '0);
    acc(1'b0, 12'hC04, '0);
    acc(1'b0, 12'h404, '0);
    // page 63 with unrelated high bits kept (R5), miss returns zero (R8)
    acc(1'b1, 12'h808, 32'hF007_E002);
    acc(1'b0, 12'h808, '0);
    acc(1'b0, 12'hFFC, '0);
    acc(1'b1, 12'hC20, 32'hDEAD_BEEF);

    // R7 back-to-back: page 5 written, paged read next cycle
    @(negedge clk);
    h_vld = 1'b1; h_we = 1'b1; h_addr = 12'h808; h_wdata = 32'h0000_A000;
    @(negedge clk);
    h_we = 1'b0; h_addr = 12'hC10; h_wdata = '0;
    m_ctrl = 32'h0000_A000;
    @(negedge clk);
    h_vld = 1'b0;
    chk(b_vld == 1'b1 && b_addr == 16'h1410, "R7 new page used at once",
        32'(b_addr), 32'h1410);
    @(negedge clk);
    chk(h_rvld == 1'b1 && h_rdata == {16'h1410 ^ 16'h5A5A, 16'h1410}, "R7 read data",
        h_rdata, {16'h1410 ^ 16'h5A5A, 16'h1410});

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned sel;
      logic [11:0] a;
      sel = $urandom % 8;
      if (sel == 0)      a = 12'h808;
      else if (sel < 4)  a = {2'b11, 10'($urandom)} & 12'hFFC;
      else               a = 12'($urandom % 12'hC00) & 12'hFFC;
      if (a == 12'h808 && sel != 0) a = 12'h80C;
      acc(1'($urandom), a, $urandom);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule